// File: doc/BRIEF.md
# I2C Byte Shift Register

This block holds the byte that an I2C interface is sending or receiving and moves it one bit at a time. It sits between the bus-side bit engine and the CPU register interface. The raw clock and data lines first pass through a small digital noise filter. An internal shift strobe is then derived from the filtered clock.

On every strobe the register moves one place towards its top bit, and the filtered data level enters at bit 0. Sending and receiving use the same path:
- **Sending:** bit 7 drives the serial output, so the top bit leaves first.
- **Receiving:** after eight strobes the first bit sampled sits in bit 7.

The CPU loads a byte through a one-cycle write strobe and can read the register at any time. A write is refused while the interface is disabled or the bus controller reports a transfer in progress. A refused write during a transfer raises a one-cycle error pulse. A byte-done pulse marks the eighth strobe of a transfer.

Top module: `i2c_byte_shifter`

## Requirements
- R1: Each filtered line changes to a new raw level only after the raw input has held that level at two consecutive clock edges. The delay is one to two clocks. A raw pulse that lasts a single clock never reaches the filtered line and causes no shift strobe.
- R2: `shift_stb` is high for exactly one clock. It rises one clock after the filtered clock line rises.
- R3: On each shift strobe, while `enable` is 1, the register moves one place left and bit 0 takes the filtered data level. After eight strobes, the first bit sampled is in bit 7.
- R4: `sda_out` follows bit 7 of the register. It changes only while the filtered clock line is low, so in a transfer the byte leaves top bit first.
- R5: A CPU write (`cpu_we`=1) loads `cpu_wdata` only when `enable`=1 and `busy`=0. A write with `enable`=0 leaves the register unchanged.
- R6: A CPU write while `busy`=1 leaves the register unchanged. `wr_err` is then 1 for exactly the following clock.
- R7: `byte_done` is a one-clock pulse in the clock after the eighth shift strobe counted since the last accepted write or `start_ind` pulse. Both of these events restart the count at zero.
- R8: `cpu_rdata` always shows the current register contents, including partway through a transfer, and reading has no effect on the transfer.
- R9: While `enable`=0, shift strobes still appear but the register and the bit count do not change.
- R10: During reset, `sda_out`=1 and `shift_stb`, `byte_done` and `wr_err` are 0. The register contents are undefined until the first accepted write or the first completed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Interface enable |
| busy | input | 1 | Transfer in progress, from the bus controller |
| start_ind | input | 1 | Start indication; restarts the bit count |
| scl_in | input | 1 | Raw serial clock line |
| sda_in | input | 1 | Raw serial data line |
| cpu_we | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Current register contents |
| sda_out | output | 1 | Serial output bit, taken from bit 7 |
| shift_stb | output | 1 | Internal shift strobe |
| byte_done | output | 1 | Eighth-strobe pulse |
| wr_err | output | 1 | Refused-write pulse |

## Verification
The bench builds the block with its default 8-bit data width. This gives a 3-bit counter, so the count wraps at the eighth strobe and the full-byte cases can be reached: a transmit loop-back byte, a received pattern, and a restart partway through a byte. The line timing places single-clock glitches and two-clock pulses against the filter. It also places CPU writes during a transfer, writes while disabled, and reads partway through a shift.

// File: rtl/i2c_shift_pkg.sv
// Package: shared constants for the I2C byte shift register.
// Assumes the data width is a power of two so the bit counter wraps naturally.
package i2c_shift_pkg;
    localparam int DATA_W     = 8;
    localparam int LINE_COUNT = 2;   // index 0: clock line, index 1: data line
    localparam int LINE_SCL   = 0;
    localparam int LINE_SDA   = 1;
endpackage

// File: rtl/i2c_glitch_filter.sv
// Module: two-sample glitch filter for one bus line.
// The output takes the raw level only when the raw level matches the previous sample.
// Assumes raw_in is already synchronous to clk (done outside this block).
module i2c_glitch_filter #(
    parameter logic RST_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic filt_out
);
    logic hist_q;
    logic filt_q;

    // Keep the last sample; pass a level on once two samples agree.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= RST_LVL;
            filt_q <= RST_LVL;
        end else begin
            hist_q <= raw_in;
            if (raw_in == hist_q) begin
                filt_q <= raw_in;
            end
        end
    end

    assign filt_out = filt_q;

    // R1: a change at the output always carries the raw level seen at that edge
    assert_filter_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_out) |-> (filt_out == $past(raw_in)));
endmodule

// File: rtl/i2c_shift_strobe.sv
// Module: makes the one-clock shift strobe that follows a filtered clock rise.
// Assumes scl_f comes from a filter that resets to the released (high) level.
module i2c_shift_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    output logic shift_stb
);
    logic scl_d_q;
    logic stb_q;

    // Delay the filtered clock and register the rise detection as the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d_q <= 1'b1;
            stb_q   <= 1'b0;
        end else begin
            scl_d_q <= scl_f;
            stb_q   <= scl_f & ~scl_d_q;
        end
    end

    assign shift_stb = stb_q;

    // R2: every filtered clock rise is followed by a strobe one clock later
    assert_stb_after_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_f) |=> shift_stb);
    // R2: the strobe never lasts two clocks
    assert_stb_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_stb |=> !shift_stb);
endmodule

// File: rtl/i2c_shift_core.sv
// Module: byte register, bit counter, write gate and serial output.
// Assumes shift_stb is a one-clock pulse and sda_f/scl_f are filtered levels.
// The register itself has no reset; its value is undefined until loaded.
module i2c_shift_core #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              busy,
    input  logic              start_ind,
    input  logic              cpu_we,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              shift_stb,
    input  logic              sda_f,
    input  logic              scl_f,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              sda_out,
    output logic              byte_done,
    output logic              wr_err
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] data_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              done_q;
    logic              err_q;
    logic              sdo_q;
    logic              wr_ok;
    logic              do_shift;

    assign wr_ok    = cpu_we & enable & ~busy;
    assign do_shift = shift_stb & enable;

    // Load from the CPU when allowed, otherwise shift on an enabled strobe.
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            data_q <= cpu_wdata;
        end else if (do_shift) begin
            data_q <= {data_q[DATA_W-2:0], sda_f};
        end
    end

    // Count strobes within the byte and flag the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (wr_ok || start_ind) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (do_shift) begin
            done_q <= (cnt_q == LAST_BIT);
            cnt_q  <= (cnt_q == LAST_BIT) ? '0 : cnt_q + 1'b1;
        end else begin
            done_q <= 1'b0;
        end
    end

    // Pulse the error flag for a write refused because a transfer is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= cpu_we & busy;
        end
    end

    // Update the serial output only while the filtered clock is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo_q <= 1'b1;
        end else if (!scl_f) begin
            sdo_q <= data_q[DATA_W-1];
        end
    end

    assign cpu_rdata = data_q;
    assign sda_out   = sdo_q;
    assign byte_done = done_q;
    assign wr_err    = err_q;

    // R4: the serial output never moves while the filtered clock was high
    assert_sdo_low_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_out) |-> !$past(scl_f));
    // R7: the byte-done pulse only follows a strobe
    assert_done_after_stb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> $past(shift_stb));
    // R6: the error pulse only follows a busy period
    assert_err_needs_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(busy));
    // R6: a refused write during a transfer leaves the register as the strobe path left it
    assert_busy_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && busy && !shift_stb) |=> $stable(cpu_rdata));
endmodule

// File: rtl/i2c_byte_shifter.sv
// Module: top of the I2C byte shift register.
// Filters both bus lines, derives the shift strobe and drives the byte core.
// Assumes scl_in/sda_in are synchronous to clk; pad drivers live elsewhere.
module i2c_byte_shifter
    import i2c_shift_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          busy,
    input  logic          start_ind,
    input  logic          scl_in,
    input  logic          sda_in,
    input  logic          cpu_we,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          sda_out,
    output logic          shift_stb,
    output logic          byte_done,
    output logic          wr_err
);
    logic [LINE_COUNT-1:0] raw_v;
    logic [LINE_COUNT-1:0] filt_v;

    assign raw_v[LINE_SCL] = scl_in;
    assign raw_v[LINE_SDA] = sda_in;

    // One glitch filter per bus line.
    for (genvar g = 0; g < LINE_COUNT; g++) begin : g_filt
        i2c_glitch_filter #(.RST_LVL(1'b1)) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_in   (raw_v[g]),
            .filt_out (filt_v[g])
        );
    end

    i2c_shift_strobe u_stb (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (filt_v[LINE_SCL]),
        .shift_stb (shift_stb)
    );

    i2c_shift_core #(.DATA_W(DW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .busy      (busy),
        .start_ind (start_ind),
        .cpu_we    (cpu_we),
        .cpu_wdata (cpu_wdata),
        .shift_stb (shift_stb),
        .sda_f     (filt_v[LINE_SDA]),
        .scl_f     (filt_v[LINE_SCL]),
        .cpu_rdata (cpu_rdata),
        .sda_out   (sda_out),
        .byte_done (byte_done),
        .wr_err    (wr_err)
    );
endmodule

// File: tb/i2c_byte_shifter_test.sv
// Bench: behavioural reference model updated on every rising edge,
// compared with the design on every falling edge, plus directed checks.
module i2c_byte_shifter_test;
    logic       clk = 1'b0;
    logic       rst_n, enable, busy, start_ind, scl_in, sda_in, cpu_we;
    logic [7:0] cpu_wdata;
    logic [7:0] cpu_rdata;
    logic       sda_out, shift_stb, byte_done, wr_err;

    int tests = 0;
    int fails = 0;
    int stb_seen = 0;
    int done_seen = 0;
    int err_seen = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    i2c_byte_shifter uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .busy(busy),
        .start_ind(start_ind), .scl_in(scl_in), .sda_in(sda_in),
        .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .sda_out(sda_out), .shift_stb(shift_stb), .byte_done(byte_done),
        .wr_err(wr_err)
    );

    // Reference model state
    bit       m_scl_prev, m_scl_lvl, m_sda_prev, m_sda_lvl, m_scl_old;
    bit       m_stb, m_done, m_err, m_sdo, m_sdo_known, m_known;
    bit [7:0] m_reg;
    int       m_bits;

    always @(posedge clk) begin : model
        bit n_scl, n_sda, accept;
        if (!rst_n) begin
            m_scl_prev = 1; m_scl_lvl = 1; m_sda_prev = 1; m_sda_lvl = 1;
            m_scl_old = 1; m_stb = 0; m_done = 0; m_err = 0; m_sdo = 1;
            m_sdo_known = 1; m_known = 0; m_bits = 0;
        end else begin
            accept = cpu_we && enable && !busy;
            if (!m_scl_lvl) begin
                m_sdo = m_reg[7];
                m_sdo_known = m_known;
            end
            if (accept) begin
                m_reg = cpu_wdata; m_known = 1; m_bits = 0; m_done = 0;
            end else begin
                if (start_ind) m_bits = 0;
                m_done = 0;
                if (m_stb && enable) begin
                    m_reg = {m_reg[6:0], m_sda_lvl};
                    if (!start_ind) begin
                        m_bits = m_bits + 1;
                        if (m_bits == 8) begin
                            m_bits = 0; m_done = 1; m_known = 1;
                        end
                    end
                end
            end
            m_err = cpu_we && busy;
            m_stb = m_scl_lvl && !m_scl_old;
            m_scl_old = m_scl_lvl;
            n_scl = (scl_in == m_scl_prev) ? scl_in : m_scl_lvl;
            n_sda = (sda_in == m_sda_prev) ? sda_in : m_sda_lvl;
            m_scl_prev = scl_in; m_sda_prev = sda_in;
            m_scl_lvl = n_scl; m_sda_lvl = n_sda;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare against the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R2 shift_stb", int'(shift_stb), int'(m_stb));
            check("R7 byte_done", int'(byte_done), int'(m_done));
            check("R6 wr_err", int'(wr_err), int'(m_err));
            if (m_sdo_known) check("R4 sda_out", int'(sda_out), int'(m_sdo));
            if (m_known) check("R8 cpu_rdata", int'(cpu_rdata), int'(m_reg));
            if (shift_stb) stb_seen++;
            if (byte_done) done_seen++;
            if (wr_err) err_seen++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cpu_write(input logic [7:0] d);
        cpu_we = 1; cpu_wdata = d;
        cyc(1);
        cpu_we = 0;
    endtask

    // One bit on the bus; optionally check the transmitted level before the clock rises.
    task automatic bus_bit(input bit v, input bit chk_tx);
        scl_in = 0; cyc(2);
        sda_in = v; cyc(3);
        if (chk_tx) check("R4 tx bit order", int'(sda_out), int'(v));
        scl_in = 1; cyc(5);
    endtask

    task automatic report;
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=done");
        report();
    end

    initial begin : main
        int s0, d0;
        rst_n = 0; enable = 0; busy = 0; start_ind = 0;
        scl_in = 1; sda_in = 1; cpu_we = 0; cpu_wdata = 8'h00;
        cyc(4);
        check("R10 reset sda_out", int'(sda_out), 1);
        check("R10 reset shift_stb", int'(shift_stb), 0);
        check("R10 reset byte_done", int'(byte_done), 0);
        check("R10 reset wr_err", int'(wr_err), 0);
        rst_n = 1; cyc(2);

        // R5: accepted write
        enable = 1;
        cpu_write(8'hA5);
        check("R5 write accepted", int'(cpu_rdata), 8'hA5);

        // R4/R6: transmit A5 with loop-back; refused write partway
        busy = 1; d0 = done_seen;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(8'hA5 >> i, 1);
            if (i == 4) begin
                cpu_write(8'h00);
                check("R6 wr_err pulse", int'(wr_err), 1);
                cyc(1);
                check("R6 wr_err one clock", int'(wr_err), 0);
            end
        end
        scl_in = 0; cyc(4);
        check("R6 busy write ignored", int'(cpu_rdata), 8'hA5);
        check("R7 done after tx byte", done_seen - d0, 1);

        // R3: receive 3C
        busy = 0; cpu_write(8'hFF); busy = 1; d0 = done_seen;
        for (int i = 7; i >= 0; i--) bus_bit(8'h3C >> i, 0);
        scl_in = 0; cyc(4);
        check("R3 received byte", int'(cpu_rdata), 8'h3C);
        check("R7 done after rx byte", done_seen - d0, 1);
        busy = 0;

        // R1: single-clock glitch on both lines
        s0 = stb_seen;
        scl_in = 1; sda_in = ~sda_in; cyc(1);
        scl_in = 0; sda_in = ~sda_in; cyc(5);
        check("R1 one-clock glitch filtered", stb_seen - s0, 0);
        check("R1 glitch leaves data", int'(cpu_rdata), 8'h3C);
        scl_in = 1; cyc(2); scl_in = 0; cyc(5);
        check("R1 two-clock pulse passes", stb_seen - s0, 1);

        // R5/R9: disabled interface
        cpu_write(8'h5A); cyc(1);
        enable = 0;
        cpu_write(8'h12); cyc(1);
        check("R5 disabled write ignored", int'(cpu_rdata), 8'h5A);
        s0 = stb_seen;
        bus_bit(1'b1, 0); bus_bit(1'b0, 0); scl_in = 0; cyc(4);
        check("R9 strobes still seen", stb_seen - s0, 2);
        check("R9 no shift while disabled", int'(cpu_rdata), 8'h5A);
        enable = 1;

        // R8: read partway through a transfer
        cpu_write(8'h81); busy = 1;
        bus_bit(1'b0, 0); scl_in = 0; cyc(4);
        check("R8 partial read", int'(cpu_rdata), 8'h02);

        // R7: start indication restarts the count
        d0 = done_seen;
        bus_bit(1'b1, 0); bus_bit(1'b1, 0);
        scl_in = 0; cyc(4);
        start_ind = 1; cyc(1); start_ind = 0;
        for (int i = 0; i < 7; i++) bus_bit(i[0], 0);
        scl_in = 0; cyc(4);
        check("R7 no done before eighth", done_seen - d0, 0);
        bus_bit(1'b1, 0); scl_in = 0; cyc(4);
        check("R7 done on eighth after start", done_seen - d0, 1);
        check("R3 byte after restart", int'(cpu_rdata), 8'h55);
        busy = 0; cyc(4);
        report();
    end
endmodule